// File: doc/BRIEF.md
# Systolic MAC array engine

This block multiplies two signed 8-bit matrices on a fixed square grid of multiply-accumulate cells. A layer is described by three sizes: M output rows, K reduction depth and N output columns. Fully-connected layers map directly. Convolutions arrive already lowered to matrix form. The engine cuts the M by N result into tiles the size of the grid. For each tile it takes K paired beats from an activation stream and a weight stream. It lets the operands ripple diagonally through the grid, so every cell keeps its own 32-bit running sum. It then hands the tile's sums out one at a time on a result stream.

Activation lane i enters at the left edge i cycles late, and weight lane j enters at the top edge j cycles late. This alignment lets matching operands meet in cell (i,j). Edge tiles that cover fewer than the full number of rows or columns switch off the unused lanes at the grid boundary. Those cells do no work and are not counted as active. For each layer the engine reports two figures: the number of cycles it was busy, and the largest number of cells that performed a multiply-accumulate in the same cycle. A one-cycle completion pulse follows the last result.

Top module: `sysmac_engine`

## Requirements
- R1: Each result equals the signed sum over k of A[r][k]*B[k][c], computed in 32-bit two's complement without saturation, for any M, K, N from 1 to 255.
- R2: Tiles are visited with the row-tile index in the outer loop and the column-tile index in the inner loop. Each tile consumes exactly K beats, where beat k carries A[m0+i][k] in act_data bits [8i+7:8i] and B[k][n0+j] in wgt_data bits [8j+7:8j]. The tile's results leave in row-major order.
- R3: Activation lanes at or beyond the tile's row count, and weight lanes at or beyond its column count, have no effect on any result.
- R4: While res_valid is high and res_ready is low, res_valid stays high and res_data holds its value. No result is dropped or repeated.
- R5: A beat is taken from both input streams in the same cycle. act_ready and wgt_ready are high only while the engine is feeding and both valids are high, and they are never high while a result is offered.
- R6: cyc_count is cleared by an accepted start. It then counts every busy cycle up to and including the cycle of the final result handshake. With no stalls this equals the sum over tiles of K + ROWS + COLS - 1 + (tile rows)*(tile columns).
- R7: peak_util is the largest number of cells that perform a multiply-accumulate in a single cycle during the layer. Cells outside the tile's rows and columns are never counted.
- R8: done is high for exactly one cycle, the cycle after the final result handshake, and the engine is idle at that point.
- R9: After reset, res_valid, act_ready, wgt_ready and done are low, and cyc_count and peak_util are zero.
- R10: A start pulse or a change of cfg_m, cfg_k or cfg_n while the engine is busy has no effect on the running layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a layer (taken only when idle) |
| cfg_m | input | DIM_W | Output rows M |
| cfg_k | input | DIM_W | Reduction depth K |
| cfg_n | input | DIM_W | Output columns N |
| act_valid | input | 1 | Activation beat present |
| act_ready | output | 1 | Activation beat taken |
| act_data | input | ROWS*DW | One signed operand per grid row |
| wgt_valid | input | 1 | Weight beat present |
| wgt_ready | output | 1 | Weight beat taken |
| wgt_data | input | COLS*DW | One signed operand per grid column |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result accepted |
| res_data | output | AW | Signed accumulated result |
| done | output | 1 | One-cycle end-of-layer pulse |
| cyc_count | output | CYC_W | Busy cycles of the last layer |
| peak_util | output | PW | Peak simultaneously active cells |

## Verification
The bench uses the default parameters: a 16 by 16 grid, 8-bit operands, 32-bit sums and 8-bit size fields. With these values one layer can fill all 256 cells at once. Layers with sizes that are not multiples of 16 give ragged tiles on both edges and a 2 by 3 tile walk. Depth-1 and all-minimum-operand layers test the arithmetic limits, and a stalled, back-pressured layer with a spurious start tests the handshakes.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DRAIN = 2'd3
  } eng_state_e;
endpackage

// File: rtl/sysmac_skew.sv
module sysmac_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] din,
  input  logic                vin,
  output logic signed [W-1:0] dout,
  output logic                vout
);
  logic signed [W-1:0] d_q [DEPTH];
  logic                v_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        d_q[s] <= '0;
        v_q[s] <= 1'b0;
      end
    end else begin
      d_q[0] <= din;
      v_q[0] <= vin;
      for (int s = 1; s < DEPTH; s++) begin
        d_q[s] <= d_q[s-1];
        v_q[s] <= v_q[s-1];
      end
    end
  end

  assign dout = d_q[DEPTH-1];
  assign vout = v_q[DEPTH-1];
endmodule

// File: rtl/sysmac_pe.sv
module sysmac_pe #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [DW-1:0] a_in,
  input  logic                 a_vin,
  input  logic signed [DW-1:0] b_in,
  input  logic                 b_vin,
  output logic signed [DW-1:0] a_out,
  output logic                 a_vout,
  output logic signed [DW-1:0] b_out,
  output logic                 b_vout,
  output logic signed [AW-1:0] acc,
  output logic                 fire
);
  function automatic logic signed [AW-1:0] mac_step(
    input logic signed [AW-1:0] sum,
    input logic signed [DW-1:0] x,
    input logic signed [DW-1:0] y
  );
    logic signed [2*DW-1:0] prod;
    prod = x * y;
    return sum + {{(AW-2*DW){prod[2*DW-1]}}, prod};
  endfunction

  assign fire = a_vin && b_vin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out  <= '0;
      a_vout <= 1'b0;
      b_out  <= '0;
      b_vout <= 1'b0;
      acc    <= '0;
    end else begin
      a_out  <= a_in;
      a_vout <= a_vin;
      b_out  <= b_in;
      b_vout <= b_vin;
      if (clr)       acc <= '0;
      else if (fire) acc <= mac_step(acc, a_in, b_in);
    end
  end
endmodule

// File: rtl/sysmac_ctrl.sv
module sysmac_ctrl
  import sysmac_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int DIM_W = 8,
  parameter int CYC_W = 32,
  parameter int PW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] cfg_m,
  input  logic [DIM_W-1:0] cfg_k,
  input  logic [DIM_W-1:0] cfg_n,
  input  logic             act_valid,
  input  logic             wgt_valid,
  input  logic             res_ready,
  input  logic [PW-1:0]    active_cnt,
  output logic             in_fire,
  output logic [DIM_W-1:0] tile_rows,
  output logic [DIM_W-1:0] tile_cols,
  output logic [DIM_W-1:0] drain_row,
  output logic [DIM_W-1:0] drain_col,
  output logic             res_valid,
  output logic             acc_clr,
  output logic             busy,
  output logic             done,
  output logic [CYC_W-1:0] cyc_count,
  output logic [PW-1:0]    peak_util
);
  localparam int FLUSH_CYC = ROWS + COLS - 1;
  localparam int FW        = $clog2(FLUSH_CYC + 1);

  eng_state_e       st_q;
  logic [DIM_W-1:0] m_q, k_q, n_q, mb_q, nb_q, kc_q, dr_q, dc_q;
  logic [FW-1:0]    fc_q;
  logic             res_fire, last_col, last_row, tile_end;
  logic             last_ntile, last_mtile, layer_end;

  function automatic logic [DIM_W-1:0] tile_span(
    input logic [DIM_W-1:0] total,
    input logic [DIM_W-1:0] base,
    input int               size
  );
    logic [DIM_W-1:0] rem;
    rem = total - base;
    return (int'(rem) > size) ? DIM_W'(size) : rem;
  endfunction

  assign tile_rows  = tile_span(m_q, mb_q, ROWS);
  assign tile_cols  = tile_span(n_q, nb_q, COLS);
  assign busy       = (st_q != ST_IDLE);
  assign in_fire    = (st_q == ST_FEED) && act_valid && wgt_valid;
  assign res_valid  = (st_q == ST_DRAIN);
  assign res_fire   = res_valid && res_ready;
  assign last_col   = (dc_q == tile_cols - 1'b1);
  assign last_row   = (dr_q == tile_rows - 1'b1);
  assign tile_end   = res_fire && last_col && last_row;
  assign last_ntile = ({1'b0, nb_q} + (DIM_W+1)'(COLS)) >= {1'b0, n_q};
  assign last_mtile = ({1'b0, mb_q} + (DIM_W+1)'(ROWS)) >= {1'b0, m_q};
  assign layer_end  = tile_end && last_ntile && last_mtile;
  assign acc_clr    = ((st_q == ST_IDLE) && start) || tile_end;
  assign drain_row  = dr_q;
  assign drain_col  = dc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      m_q <= '0; k_q <= '0; n_q <= '0; mb_q <= '0; nb_q <= '0;
      kc_q <= '0; dr_q <= '0; dc_q <= '0; fc_q <= '0;
      done <= 1'b0;
      cyc_count <= '0;
      peak_util <= '0;
    end else begin
      done <= layer_end;
      if (busy) begin
        cyc_count <= cyc_count + 1'b1;
        if (active_cnt > peak_util) peak_util <= active_cnt;
      end
      unique case (st_q)
        ST_IDLE: if (start) begin
          m_q <= cfg_m; k_q <= cfg_k; n_q <= cfg_n;
          mb_q <= '0; nb_q <= '0; kc_q <= '0;
          cyc_count <= '0;
          peak_util <= '0;
          st_q <= ST_FEED;
        end
        ST_FEED: if (in_fire) begin
          if (kc_q == k_q - 1'b1) begin
            fc_q <= '0;
            st_q <= ST_FLUSH;
          end else begin
            kc_q <= kc_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (fc_q == FW'(FLUSH_CYC - 1)) begin
            dr_q <= '0;
            dc_q <= '0;
            st_q <= ST_DRAIN;
          end else begin
            fc_q <= fc_q + 1'b1;
          end
        end
        ST_DRAIN: if (res_fire) begin
          if (!last_col) begin
            dc_q <= dc_q + 1'b1;
          end else if (!last_row) begin
            dc_q <= '0;
            dr_q <= dr_q + 1'b1;
          end else begin
            kc_q <= '0;
            if (last_ntile) begin
              nb_q <= '0;
              if (last_mtile) begin
                st_q <= ST_IDLE;
              end else begin
                mb_q <= mb_q + DIM_W'(ROWS);
                st_q <= ST_FEED;
              end
            end else begin
              nb_q <= nb_q + DIM_W'(COLS);
              st_q <= ST_FEED;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sysmac_engine.sv
module sysmac_engine #(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  parameter int AW    = 32,
  parameter int DIM_W = 8,
  parameter int CYC_W = 32,
  localparam int PW   = $clog2(ROWS * COLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIM_W-1:0]   cfg_m,
  input  logic [DIM_W-1:0]   cfg_k,
  input  logic [DIM_W-1:0]   cfg_n,
  input  logic               act_valid,
  output logic               act_ready,
  input  logic [ROWS*DW-1:0] act_data,
  input  logic               wgt_valid,
  output logic               wgt_ready,
  input  logic [COLS*DW-1:0] wgt_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [AW-1:0]      res_data,
  output logic               done,
  output logic [CYC_W-1:0]   cyc_count,
  output logic [PW-1:0]      peak_util
);
  localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CIW = (COLS > 1) ? $clog2(COLS) : 1;

  logic             in_fire, acc_clr, busy;
  logic [DIM_W-1:0] tile_rows, tile_cols, drain_row, drain_col;
  logic [PW-1:0]    active_cnt;

  logic signed [DW-1:0] a_h  [ROWS][COLS+1];
  logic                 av_h [ROWS][COLS+1];
  logic signed [DW-1:0] b_v  [ROWS+1][COLS];
  logic                 bv_v [ROWS+1][COLS];
  logic signed [AW-1:0] acc_m  [ROWS][COLS];
  logic                 fire_m [ROWS][COLS];

  sysmac_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .DIM_W(DIM_W), .CYC_W(CYC_W), .PW(PW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_n(cfg_n),
    .act_valid(act_valid), .wgt_valid(wgt_valid), .res_ready(res_ready),
    .active_cnt(active_cnt), .in_fire(in_fire),
    .tile_rows(tile_rows), .tile_cols(tile_cols),
    .drain_row(drain_row), .drain_col(drain_col),
    .res_valid(res_valid), .acc_clr(acc_clr), .busy(busy), .done(done),
    .cyc_count(cyc_count), .peak_util(peak_util)
  );

  assign act_ready = in_fire;
  assign wgt_ready = in_fire;

  // Left edge: lane i gated by tile height, delayed i+1 cycles
  for (genvar i = 0; i < ROWS; i++) begin : g_row_edge
    logic                 lane_on;
    logic signed [DW-1:0] lane_d;
    assign lane_on = in_fire && (DIM_W'(i) < tile_rows);
    assign lane_d  = lane_on ? act_data[i*DW +: DW] : '0;
    sysmac_skew #(.W(DW), .DEPTH(i + 1)) skew_i (
      .clk(clk), .rst_n(rst_n), .din(lane_d), .vin(lane_on),
      .dout(a_h[i][0]), .vout(av_h[i][0])
    );
  end

  // Top edge: lane j gated by tile width, delayed j+1 cycles
  for (genvar j = 0; j < COLS; j++) begin : g_col_edge
    logic                 lane_on;
    logic signed [DW-1:0] lane_d;
    assign lane_on = in_fire && (DIM_W'(j) < tile_cols);
    assign lane_d  = lane_on ? wgt_data[j*DW +: DW] : '0;
    sysmac_skew #(.W(DW), .DEPTH(j + 1)) skew_i (
      .clk(clk), .rst_n(rst_n), .din(lane_d), .vin(lane_on),
      .dout(b_v[0][j]), .vout(bv_v[0][j])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_pe_row
    for (genvar c = 0; c < COLS; c++) begin : g_pe_col
      sysmac_pe #(.DW(DW), .AW(AW)) pe_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr),
        .a_in(a_h[r][c]), .a_vin(av_h[r][c]),
        .b_in(b_v[r][c]), .b_vin(bv_v[r][c]),
        .a_out(a_h[r][c+1]), .a_vout(av_h[r][c+1]),
        .b_out(b_v[r+1][c]), .b_vout(bv_v[r+1][c]),
        .acc(acc_m[r][c]), .fire(fire_m[r][c])
      );
    end
  end

  always_comb begin
    active_cnt = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        active_cnt = active_cnt + PW'(fire_m[r][c]);
  end

  assign res_data = acc_m[drain_row[RIW-1:0]][drain_col[CIW-1:0]];
endmodule

// File: rtl/sysmac_engine_chk.sv
module sysmac_engine_chk #(
  parameter int AW    = 32,
  parameter int DIM_W = 8,
  parameter int PW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             act_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [AW-1:0]    res_data,
  input logic             done,
  input logic [PW-1:0]    peak_util,
  input logic [PW-1:0]    active_cnt,
  input logic [DIM_W-1:0] tile_rows,
  input logic [DIM_W-1:0] tile_cols
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!res_valid && !act_ready));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_res_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_feed_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_ready |-> !res_valid);

  // R3 and R7: cells outside the tile never fire
  p_gate_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_cnt) <= int'(tile_rows) * int'(tile_cols));

  p_peak_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (peak_util >= $past(peak_util)));
endmodule

bind sysmac_engine sysmac_engine_chk #(.AW(AW), .DIM_W(DIM_W), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .act_ready(act_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .done(done), .peak_util(peak_util), .active_cnt(active_cnt),
  .tile_rows(tile_rows), .tile_cols(tile_cols)
);

// File: tb/sysmac_engine_tb_top.sv
module sysmac_engine_tb_top;
  localparam int G = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [7:0]     cfg_m = '0, cfg_k = '0, cfg_n = '0;
  logic           act_valid = 1'b0, wgt_valid = 1'b0, res_ready = 1'b1;
  logic [G*8-1:0] act_data = '0, wgt_data = '0;
  logic           act_ready, wgt_ready, res_valid, done;
  logic [31:0]    res_data, cyc_count;
  logic [8:0]     peak_util;

  always #4 clk = ~clk;

  sysmac_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_n(cfg_n),
    .act_valid(act_valid), .act_ready(act_ready), .act_data(act_data),
    .wgt_valid(wgt_valid), .wgt_ready(wgt_ready), .wgt_data(wgt_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .done(done), .cyc_count(cyc_count), .peak_util(peak_util)
  );

  int nchk = 0, nfail = 0;
  int A [0:39][0:63];
  int B [0:63][0:39];
  logic [G*8-1:0] ab [0:1023];
  logic [G*8-1:0] wb [0:1023];
  int ex [0:2047];
  int nbeats, nres, exp_cyc;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int util_of(input int r, input int c, input int k);
    int best = 0;
    for (int t = 0; t < r + c + k; t++) begin
      int cnt = 0;
      for (int i = 0; i < r; i++)
        for (int j = 0; j < c; j++)
          if (t - i - j >= 0 && t - i - j < k) cnt++;
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  function automatic int mn(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  task automatic build(input int m, input int k, input int n);
    int mt = (m + G - 1) / G;
    int nt = (n + G - 1) / G;
    nbeats = 0; nres = 0; exp_cyc = 0;
    for (int ti = 0; ti < mt; ti++)
      for (int tj = 0; tj < nt; tj++) begin
        int tr = mn(G, m - ti * G);
        int tc = mn(G, n - tj * G);
        for (int kk = 0; kk < k; kk++) begin
          for (int l = 0; l < G; l++) begin
            int row = ti * G + l;
            int col = tj * G + l;
            ab[nbeats][l*8 +: 8] = (row < m) ? 8'(A[row][kk]) : 8'($urandom);
            wb[nbeats][l*8 +: 8] = (col < n) ? 8'(B[kk][col]) : 8'($urandom);
          end
          nbeats++;
        end
        for (int r = 0; r < tr; r++)
          for (int c = 0; c < tc; c++) begin
            int s = 0;
            for (int kk = 0; kk < k; kk++) s += A[ti*G + r][kk] * B[kk][tj*G + c];
            ex[nres] = s;
            nres++;
          end
        exp_cyc += k + 2 * G - 1 + tr * tc;
      end
  endtask

  task automatic fill(input int m, input int k, input int n, input int mode);
    for (int r = 0; r < m; r++)
      for (int kk = 0; kk < k; kk++)
        A[r][kk] = (mode == 1) ? -128 : int'($signed(8'($urandom)));
    for (int kk = 0; kk < k; kk++)
      for (int c = 0; c < n; c++)
        B[kk][c] = (mode == 1) ? -128 : int'($signed(8'($urandom)));
  endtask

  // stress=1: random backpressure, an input stall and a spurious start
  task automatic run_layer(input int m, input int k, input int n, input int mode,
                           input bit stress, input string req);
    fill(m, k, n, mode);
    build(m, k, n);
    @(posedge clk); #1;
    cfg_m = 8'(m); cfg_k = 8'(k); cfg_n = 8'(n);
    start = 1'b1;
    act_valid = 1'b1; wgt_valid = 1'b1;
    act_data = ab[0]; wgt_data = wb[0];
    res_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    fork
      begin : feed
        int idx = 0;
        while (idx < nbeats) begin
          bit f;
          @(negedge clk);
          f = act_ready && wgt_ready;
          @(posedge clk); #1;
          if (f) begin
            idx++;
            if (idx < nbeats) begin
              act_data = ab[idx]; wgt_data = wb[idx];
            end else begin
              act_valid = 1'b0; wgt_valid = 1'b0;
            end
            if (stress && idx == 2) begin
              wgt_valid = 1'b0;
              repeat (3) begin
                @(negedge clk);
                chk(!act_ready && !wgt_ready, "R5 ready with one valid low", act_ready, 0);
              end
              @(posedge clk); #1;
              wgt_valid = 1'b1;
            end
          end
        end
      end
      begin : drain
        int got = 0;
        while (got < nres) begin
          @(negedge clk);
          if (res_valid && res_ready) begin
            chk($signed(res_data) == ex[got], req, $signed(res_data), ex[got]);
            got++;
          end
          @(posedge clk); #1;
          res_ready = stress ? 1'($urandom) : 1'b1;
        end
        res_ready = 1'b1;
        @(negedge clk);
        chk(done == 1'b1, "R8 done after last result", done, 1);
        if (!stress) begin
          chk(cyc_count == 32'(exp_cyc), "R6 cycle count", cyc_count, exp_cyc);
          chk(int'(peak_util) == util_of(mn(m, G), mn(n, G), k), "R7 peak utilization",
              peak_util, util_of(mn(m, G), mn(n, G), k));
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(!res_valid, "R8 idle after done", res_valid, 0);
      end
      begin : spurious
        if (stress) begin
          repeat (6) @(posedge clk);
          #1;
          start = 1'b1; cfg_m = 8'd3; cfg_k = 8'd2; cfg_n = 8'd9;
          @(posedge clk); #1;
          start = 1'b0;
        end
      end
    join
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && !act_ready && !wgt_ready && !done, "R9 reset outputs",
        {res_valid, act_ready, wgt_ready, done}, 0);
    chk(cyc_count == 0 && peak_util == 0, "R9 reset counters", cyc_count + peak_util, 0);

    run_layer(3, 5, 4, 0, 1'b0, "R1 R2 small layer");
    run_layer(16, 40, 16, 0, 1'b0, "R1 R2 full tile");
    run_layer(20, 7, 33, 0, 1'b0, "R3 R2 ragged tiles");
    run_layer(1, 1, 1, 0, 1'b0, "R1 depth one");
    run_layer(16, 30, 16, 1, 1'b0, "R1 minimum operands");
    run_layer(17, 12, 5, 0, 1'b1, "R4 R10 stressed layer");
    run_layer(5, 20, 12, 0, 1'b0, "R10 R1 after spurious start");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule